// File: doc/BRIEF.md
# Step Attenuator Programmer

This block sits on the host side of a 6-bit RF step attenuator and writes one attenuation code to it per transfer. A requester offers a code with a valid/ready handshake. The block then drives the attenuator's control pins in one of two ways. In serial mode it produces a clock, a data line and a latch strobe, shifting the code out one bit at a time. In latched-parallel mode it presents all six bits at once and then strobes the latch. The code weights are fixed: bit 5 is 16 dB, bit 4 is 8 dB, bit 3 is 4 dB, bit 2 is 2 dB, bit 1 is 1 dB and bit 0 is 0.5 dB.

Every edge on the control pins is placed by a count of system clock cycles. Each count is a parameter, rounded up from the attenuator's nanosecond limit for the chosen clock. When the attenuator runs from its internal negative supply, updates must be spaced out. A per-transfer input selects this low-rate spacing. It holds the handshake off for a programmable interval after each latch strobe.

Top module: `atten_prog`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising clock edge), sclk_o, sdat_o, le_o and par_o are all 0 and ready_o is 1. This holds even when the reset arrives in the middle of a transfer.
- R2: A serial transfer produces exactly six rising edges on sclk_o. The values of sdat_o at those edges, in order, are code bits 5 down to 0, so the 16 dB bit goes first and the 0.5 dB bit goes last.
- R3: Every high phase of sclk_o lasts exactly SCK_HI_CYC cycles. Every low phase that ends in a rising edge lasts exactly SCK_LO_CYC cycles, counted from acceptance for the first bit.
- R4: sdat_o does not change in any cycle in which sclk_o is high. It is set at least SCK_LO_CYC cycles before each rising edge and held through the whole high phase.
- R5: In serial mode, le_o stays low while the six bits are shifted. After the last bit, le_o rises LE_DLY_CYC cycles after sclk_o falls, and it gives one pulse of exactly LE_PW_CYC cycles. sclk_o and le_o are never high together.
- R6: In latched-parallel mode, par_o takes the accepted code at least PAR_SU_CYC cycles before le_o rises. le_o pulses high for exactly PAR_PW_CYC cycles, and sclk_o does not toggle. par_o is stable while le_o is high, keeps its value afterwards, and is not touched by serial transfers.
- R7: ready_o falls in the cycle after a code is accepted. It stays low until the transfer ends. With low_rate_i = 0, ready_o rises in the same cycle that le_o falls (serial) or PAR_HD_CYC cycles after it (parallel). With low_rate_i = 1, ready_o rises a further GAP_CYC cycles later.
- R8: A code offered while ready_o is low is neither accepted nor lost. The transfer in progress keeps the code captured at its acceptance. The waiting code is taken on the first cycle that ready_o is high again.
- R9: While idle, sclk_o and le_o are low and sdat_o keeps the last serial bit sent (bit 0 of the last serial code). A parallel transfer leaves sdat_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_i | input | 6 | Attenuation code, bit 5 = 16 dB down to bit 0 = 0.5 dB |
| mode_par_i | input | 1 | 1 = latched parallel, 0 = serial; sampled at acceptance |
| low_rate_i | input | 1 | 1 = enforce the minimum update interval; sampled at acceptance |
| valid_i | input | 1 | Code offered |
| ready_o | output | 1 | Block idle, offered code is taken this cycle |
| sclk_o | output | 1 | Serial clock to the attenuator |
| sdat_o | output | 1 | Serial data to the attenuator |
| le_o | output | 1 | Latch strobe to the attenuator |
| par_o | output | 6 | Parallel control bits to the attenuator |

## Verification
The state register and the phase counter cannot be seen directly, so a wrong value shows as a distorted waveform on the pins. A phase counter that is off by one changes the measured high or low width of the clock, or the latch width, within the first bit of the transfer. A misdecoded state shows as a missing or extra clock edge, or a shifted captured word, by the time the latch strobe rises. A broken interval timer or return path shows as ready_o coming back too early or too late, measured in cycles from the falling strobe.

// File: rtl/atten_prog_pkg.sv
// Shared types and helpers for the step attenuator programmer.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package atten_prog_pkg;

    // Sequencer phases; S_* are serial, P_* latched parallel.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SLOW,
        ST_SHIGH,
        ST_LEDLY,
        ST_SLATCH,
        ST_PSETUP,
        ST_PLATCH,
        ST_PHOLD,
        ST_GAP
    } prog_state_t;

    // Larger of two integers, used to size the phase counter.
    function automatic int pmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/atten_tick_timer.sv
// Loadable down-counter that times one phase.
// Loading N-1 makes zero_o rise after N cycles in the phase.
// Assumes: load has priority; the counter rests at zero.
module atten_tick_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero_o
);
    logic [W-1:0] cnt;

    // Count down to zero after each load.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);
endmodule

// File: rtl/atten_shifter.sv
// MSB-first shifter for the serial data line.
// dat_o is a register that changes only on load or shift, so it keeps
// the last bit sent while the block is idle.
// Assumes: BITS >= 3; shift is requested only while last_o is low.
module atten_shifter #(
    parameter int BITS = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] code,
    input  logic            shift,
    output logic            dat_o,
    output logic            last_o
);
    localparam int CW = $clog2(BITS);

    logic [BITS-2:0] rest;
    logic [CW-1:0]   left;

    // Present the top bit on load, the next one on each shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rest  <= '0;
            left  <= '0;
            dat_o <= 1'b0;
        end else if (load) begin
            rest  <= code[BITS-2:0];
            dat_o <= code[BITS-1];
            left  <= CW'(BITS-1);
        end else if (shift) begin
            dat_o <= rest[BITS-2];
            rest  <= {rest[BITS-3:0], 1'b0};
            left  <= left - 1'b1;
        end
    end

    assign last_o = (left == '0);
endmodule

// File: rtl/atten_prog.sv
// Step attenuator programmer: takes a code over valid/ready and drives
// the attenuator's serial (clock/data/latch) or latched-parallel pins.
// Every phase length is a count of system clock cycles.
// Assumes: all *_CYC parameters >= 1, derived from the nanosecond limits.
module atten_prog
    import atten_prog_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int SCK_LO_CYC  = 3,    // clock low, also the data setup
    parameter int SCK_HI_CYC  = 2,    // clock high, also the data hold
    parameter int LE_DLY_CYC  = 1,    // last falling clock to latch rise
    parameter int LE_PW_CYC   = 2,    // serial latch pulse
    parameter int PAR_SU_CYC  = 1,    // parallel data setup to latch
    parameter int PAR_PW_CYC  = 1,    // parallel latch pulse
    parameter int PAR_HD_CYC  = 1,    // parallel hold after latch
    parameter int GAP_CYC     = 2000  // minimum update interval (low rate)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              mode_par_i,
    input  logic              low_rate_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              sclk_o,
    output logic              sdat_o,
    output logic              le_o,
    output logic [CODE_W-1:0] par_o
);
    localparam int PH_MAX = pmax(pmax(pmax(SCK_LO_CYC, SCK_HI_CYC),
                                      pmax(LE_DLY_CYC, LE_PW_CYC)),
                                 pmax(pmax(PAR_SU_CYC, PAR_PW_CYC), PAR_HD_CYC));
    localparam int PH_W  = $clog2(PH_MAX + 1);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    prog_state_t     st, st_n;
    logic            ph_load, ph_zero;
    logic [PH_W-1:0] ph_val;
    logic            gap_load, gap_zero;
    logic            sh_load, sh_shift, sh_last;
    logic            low_rate_q;
    logic            accept;

    assign ready_o = (st == ST_IDLE);
    assign accept  = valid_i && ready_o;

    atten_tick_timer #(.W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero_o(ph_zero)
    );

    atten_tick_timer #(.W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load),
        .load_val(GAP_W'(GAP_CYC - 1)), .zero_o(gap_zero)
    );

    atten_shifter #(.BITS(CODE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .code(code_i),
        .shift(sh_shift), .dat_o(sdat_o), .last_o(sh_last)
    );

    // Next phase, timer loads and shifter commands.
    always_comb begin
        st_n     = st;
        ph_load  = 1'b0;
        ph_val   = '0;
        gap_load = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (st)
            ST_IDLE: if (valid_i) begin
                ph_load = 1'b1;
                if (mode_par_i) begin
                    st_n   = ST_PSETUP;
                    ph_val = PH_W'(PAR_SU_CYC - 1);
                end else begin
                    sh_load = 1'b1;
                    st_n    = ST_SLOW;
                    ph_val  = PH_W'(SCK_LO_CYC - 1);
                end
            end
            ST_SLOW: if (ph_zero) begin
                st_n    = ST_SHIGH;
                ph_load = 1'b1;
                ph_val  = PH_W'(SCK_HI_CYC - 1);
            end
            ST_SHIGH: if (ph_zero) begin
                ph_load = 1'b1;
                if (sh_last) begin
                    st_n   = ST_LEDLY;
                    ph_val = PH_W'(LE_DLY_CYC - 1);
                end else begin
                    sh_shift = 1'b1;
                    st_n     = ST_SLOW;
                    ph_val   = PH_W'(SCK_LO_CYC - 1);
                end
            end
            ST_LEDLY: if (ph_zero) begin
                st_n    = ST_SLATCH;
                ph_load = 1'b1;
                ph_val  = PH_W'(LE_PW_CYC - 1);
            end
            ST_SLATCH: if (ph_zero) begin
                st_n     = low_rate_q ? ST_GAP : ST_IDLE;
                gap_load = low_rate_q;
            end
            ST_PSETUP: if (ph_zero) begin
                st_n    = ST_PLATCH;
                ph_load = 1'b1;
                ph_val  = PH_W'(PAR_PW_CYC - 1);
            end
            ST_PLATCH: if (ph_zero) begin
                st_n    = ST_PHOLD;
                ph_load = 1'b1;
                ph_val  = PH_W'(PAR_HD_CYC - 1);
            end
            ST_PHOLD: if (ph_zero) begin
                st_n     = low_rate_q ? ST_GAP : ST_IDLE;
                gap_load = low_rate_q;
            end
            ST_GAP: if (gap_zero) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // State, registered pin outputs and per-transfer settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            sclk_o     <= 1'b0;
            le_o       <= 1'b0;
            par_o      <= '0;
            low_rate_q <= 1'b0;
        end else begin
            st     <= st_n;
            sclk_o <= (st_n == ST_SHIGH);
            le_o   <= (st_n == ST_SLATCH) || (st_n == ST_PLATCH);
            if (accept) begin
                low_rate_q <= low_rate_i;
                if (mode_par_i) par_o <= code_i;
            end
        end
    end
endmodule

// File: rtl/atten_prog_chk.sv
// Port-level protocol checker for atten_prog, attached by bind.
// Assumes: synchronous active-low reset; widths are checked with
// saturating run counters rather than deep $past.
module atten_prog_chk #(
    parameter int CODE_W     = 6,
    parameter int SCK_HI_CYC = 2,
    parameter int LE_MIN_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic              ready_o,
    input logic              sclk_o,
    input logic              sdat_o,
    input logic              le_o,
    input logic [CODE_W-1:0] par_o
);
    logic [7:0] hi_run, le_run;

    // Length of the current high run on the clock and latch pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            le_run <= '0;
        end else begin
            hi_run <= sclk_o ? ((hi_run == 8'hFF) ? hi_run : hi_run + 8'd1) : 8'd0;
            le_run <= le_o   ? ((le_run == 8'hFF) ? le_run : le_run + 8'd1) : 8'd0;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ready_o && !sclk_o && !le_o && !sdat_o && par_o == '0));

    // R3
    sclk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_run >= 8'(SCK_HI_CYC)));

    // R4
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sdat_o));

    // R5
    sclk_le_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_o && le_o));

    // R5
    le_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(le_o) |-> (le_run >= 8'(LE_MIN_CYC)));

    // R6
    par_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_o |-> $stable(par_o));

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> !ready_o);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!sclk_o && !le_o));
endmodule

bind atten_prog atten_prog_chk #(
    .CODE_W    (CODE_W),
    .SCK_HI_CYC(SCK_HI_CYC),
    .LE_MIN_CYC((LE_PW_CYC < PAR_PW_CYC) ? LE_PW_CYC : PAR_PW_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .ready_o(ready_o),
    .sclk_o(sclk_o), .sdat_o(sdat_o), .le_o(le_o), .par_o(par_o)
);

// File: tb/atten_prog_bench.sv
module atten_prog_bench;
    localparam int LO  = 3;
    localparam int HI  = 2;
    localparam int LED = 1;
    localparam int LPW = 2;
    localparam int PSU = 1;
    localparam int PPW = 1;
    localparam int PHD = 1;
    localparam int GAP = 400;

    // {parallel, low_rate, code}
    localparam logic [7:0] VECS [0:9] = '{
        {2'b00, 6'h2A}, {2'b00, 6'h15}, {2'b00, 6'h3F}, {2'b00, 6'h00},
        {2'b01, 6'h21}, {2'b10, 6'h3F}, {2'b10, 6'h01}, {2'b11, 6'h2C},
        {2'b00, 6'h20}, {2'b01, 6'h1E}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] code_i = '0;
    logic       mode_par_i = 1'b0, low_rate_i = 1'b0, valid_i = 1'b0;
    logic       ready_o, sclk_o, sdat_o, le_o;
    logic [5:0] par_o;

    int checks = 0, fails = 0;
    logic [5:0] exp_par = '0;
    logic       exp_dat = 1'b0;

    // monitor state
    int nbits, bad_hi, bad_lo, glitch, le_pulses, le_w, bits_at_le, gap_len;
    int lo_run, hi_run, par_run, par_su;
    logic le_done;
    logic [5:0] cap;
    logic prev_ready = 1'b1, prev_sclk = 1'b0, prev_le = 1'b0, prev_dat = 1'b0;
    logic [5:0] prev_par = '0;

    always #10 clk = ~clk;

    atten_prog #(
        .CODE_W(6), .SCK_LO_CYC(LO), .SCK_HI_CYC(HI), .LE_DLY_CYC(LED),
        .LE_PW_CYC(LPW), .PAR_SU_CYC(PSU), .PAR_PW_CYC(PPW),
        .PAR_HD_CYC(PHD), .GAP_CYC(GAP)
    ) u_atten_prog (
        .clk(clk), .rst_n(rst_n), .code_i(code_i), .mode_par_i(mode_par_i),
        .low_rate_i(low_rate_i), .valid_i(valid_i), .ready_o(ready_o),
        .sclk_o(sclk_o), .sdat_o(sdat_o), .le_o(le_o), .par_o(par_o)
    );

    task automatic clear_mon();
        nbits = 0; bad_hi = 0; bad_lo = 0; glitch = 0; le_pulses = 0; le_w = 0;
        bits_at_le = 0; gap_len = 0; lo_run = 0; hi_run = 0; par_su = 0;
        le_done = 1'b0; cap = '0;
    endtask

    // Waveform monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            clear_mon();
            par_run = 0;
            prev_ready = 1'b1; prev_sclk = 1'b0; prev_le = 1'b0;
            prev_dat = 1'b0; prev_par = '0;
        end else begin
            if (prev_ready && !ready_o) clear_mon();
            if (sclk_o) begin
                if (sdat_o !== prev_dat) glitch++;
                if (!prev_sclk) begin
                    cap = {cap[4:0], sdat_o};
                    nbits++;
                    if (lo_run != LO) bad_lo++;
                    lo_run = 0;
                end
                hi_run++;
            end else begin
                if (prev_sclk) begin
                    if (hi_run != HI) bad_hi++;
                    hi_run = 0;
                end
                if (!ready_o) lo_run++;
            end
            if (le_o) begin
                if (!prev_le) begin
                    le_pulses++;
                    bits_at_le = nbits;
                    par_su = par_run;
                end
                le_w++;
            end else if (prev_le) le_done = 1'b1;
            if (le_done && !le_o && !ready_o) gap_len++;
            if (par_o != prev_par) par_run = 1; else par_run++;
            prev_ready = ready_o; prev_sclk = sclk_o; prev_le = le_o;
            prev_dat = sdat_o; prev_par = par_o;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        while (!ready_o) @(negedge clk);
        #1;
    endtask

    task automatic run_vec(input logic par, input logic slow, input logic [5:0] code);
        @(negedge clk);
        while (!ready_o) @(negedge clk);
        code_i = code; mode_par_i = par; low_rate_i = slow; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        chk(!ready_o, "R7 busy after accept", ready_o, 0);
        wait_ready();
        if (!par) begin
            chk(nbits == 6, "R2 edge count", nbits, 6);
            chk(cap == code, "R2 word", cap, code);
            chk(bad_hi == 0, "R3 high width", bad_hi, 0);
            chk(bad_lo == 0, "R3 low width", bad_lo, 0);
            chk(glitch == 0, "R4 data change while high", glitch, 0);
            chk(le_pulses == 1 && bits_at_le == 6, "R5 latch after shift", bits_at_le, 6);
            chk(le_w == LPW, "R5 latch width", le_w, LPW);
            chk(gap_len == (slow ? GAP : 0), "R7 return", gap_len, slow ? GAP : 0);
            chk(sdat_o == code[0], "R9 idle data", sdat_o, code[0]);
            chk(par_o == exp_par, "R6 par untouched", par_o, exp_par);
            exp_dat = code[0];
        end else begin
            chk(par_o == code, "R6 par value", par_o, code);
            chk(nbits == 0, "R6 no clock", nbits, 0);
            chk(le_pulses == 1 && le_w == PPW, "R6 latch width", le_w, PPW);
            chk(par_su >= PSU, "R6 setup", par_su, PSU);
            chk(gap_len == (slow ? PHD + GAP : PHD), "R7 return", gap_len, slow ? PHD + GAP : PHD);
            chk(sdat_o == exp_dat, "R9 data kept", sdat_o, exp_dat);
            exp_par = code;
        end
        chk(!sclk_o && !le_o, "R9 idle pins", {sclk_o, le_o}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R7 watchdog: actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o && !sclk_o && !le_o && !sdat_o && par_o == 0, "R1 reset state",
            {ready_o, sclk_o, le_o, sdat_o}, 4'b1000);

        for (int i = 0; i < 10; i++)
            run_vec(VECS[i][7], VECS[i][6], VECS[i][5:0]);

        // R8: second code held off while busy, then taken
        @(negedge clk);
        code_i = 6'h35; mode_par_i = 1'b0; low_rate_i = 1'b0; valid_i = 1'b1;
        @(negedge clk);
        code_i = 6'h0B;
        wait_ready();
        chk(cap == 6'h35, "R8 first word kept", cap, 6'h35);
        @(negedge clk);
        chk(!ready_o, "R8 waiting code taken", ready_o, 0);
        valid_i = 1'b0;
        wait_ready();
        chk(cap == 6'h0B, "R8 second word", cap, 6'h0B);
        chk(sdat_o == 1'b1, "R9 idle data after R8", sdat_o, 1);

        // R1: reset in the middle of a transfer
        @(negedge clk);
        code_i = 6'h3F; mode_par_i = 1'b0; low_rate_i = 1'b1; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(ready_o && !sclk_o && !le_o && !sdat_o && par_o == 0, "R1 mid-transfer reset",
            {ready_o, sclk_o, le_o, sdat_o}, 4'b1000);
        rst_n = 1'b1;
        exp_par = '0; exp_dat = 1'b0;
        run_vec(1'b0, 1'b0, 6'h12);
        run_vec(1'b1, 1'b0, 6'h2D);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule